// File: doc/BRIEF.md
# PLL Divider Parameter Search Engine

This block works out a divider setting for a phase-locked loop from two integer frequencies in hertz: the reference clock `fin` and the wanted output `fout`. A setting has three fields. The post-scaler `s` gives the VCO frequency as `fout << s`. The pre-divider `p` and the main multiplier `m` bracket that VCO frequency between `m*fin/p` and `(m+1)*fin/p`. The block walks these fields in a fixed nested order, one candidate per clock, and returns the first setting that fits. A fractional correction term is not produced, so the caller treats it as zero.

Software or a boot sequencer pulses `start` with both frequencies held on the inputs and waits for the one-cycle `done` pulse. `found` then tells whether a setting exists. The field outputs keep their values until the next accepted start. The VCO window and the scan limits are parameters. By default the window is 2.25 GHz to 4.5 GHz inclusive, `s` runs 0..6, `p` runs 1..4 and `m` runs 64..1023.

Top module: `pll_param_search`

## Requirements
- R1: The post-scaler is tried in ascending order from 0 to 6 inclusive, and the VCO frequency for a trial value is `fout` shifted left by that value.
- R2: A post-scaler value whose VCO frequency is below VCO_MIN or above VCO_MAX is rejected in one clock cycle, and no divider pair is tried for it. With every value rejected, `done` rises exactly 7 clock edges after the edge that accepted `start`.
- R3: For each accepted post-scaler, `p` is tried from 1 to 4 inclusive, and for each `p`, `m` is tried from 64 to 1023 inclusive, one candidate per clock.
- R4: A candidate fits when `fvco >= floor(m*fin/p)` and `fvco < floor((m+1)*fin/p)`. The result is the first fitting candidate in the order post-scaler, then `p`, then `m`. For example, fin = 24 MHz and fout = 1.5 GHz give s=1, p=1, m=125.
- R5: When no candidate fits anywhere in the scan, `done` pulses with `found` = 0 and `p_o`, `m_o` and `s_o` all 0.
- R6: `done` is high for exactly one cycle per search. `found`, `p_o`, `m_o` and `s_o` change only on that cycle and then hold until the next accepted start.
- R7: A `start` pulse that arrives while a search is running is ignored, and the running search finishes with its own operands.
- R8: After reset, `done`, `found`, `p_o`, `m_o` and `s_o` are all 0.
- R9: Once `floor(m*fin/p)` exceeds the VCO frequency, the rest of the `m` range for that `p` is skipped. This shortcut never changes the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a search when idle; operands are sampled on the same edge |
| fin | input | FW | Reference frequency in Hz |
| fout | input | FW | Target output frequency in Hz |
| done | output | 1 | One-cycle pulse marking the end of a search |
| found | output | 1 | A fitting setting was found |
| p_o | output | PW | Pre-divider result |
| m_o | output | MW | Main multiplier result |
| s_o | output | SW | Post-scaler result |

## Verification
A corrupted scan counter or a wrong bracket compare becomes visible only when `done` pulses. It shows up as a different field triple, or as `found` dropping for a target that does have a setting, so every scenario is compared with an independent model of the nested scan. A bad VCO window gate shows earlier, as a change in latency. A target outside the window everywhere must finish after exactly seven cycles. An early-exit condition that is too eager loses valid settings, and targets that need `p` above 1 expose it. Outputs that drift between searches, and restarts caused by a stray `start` during a scan, are seen on the cycles after `done` and in the result of the interrupted search.

// File: rtl/pll_param_search.sv
module pll_param_search #(
  parameter int FW = 64,
  parameter logic [63:0] VCO_MIN = 64'd2250000000,
  parameter logic [63:0] VCO_MAX = 64'd4500000000,
  parameter int S_LAST = 6,
  parameter int P_FIRST = 1,
  parameter int P_LAST = 4,
  parameter int M_FIRST = 64,
  parameter int M_LAST = 1023,
  localparam int SW = $clog2(S_LAST + 1),
  localparam int PW = $clog2(P_LAST + 1),
  localparam int MW = $clog2(M_LAST + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [FW-1:0] fin,
  input  logic [FW-1:0] fout,
  output logic          done,
  output logic          found,
  output logic [PW-1:0] p_o,
  output logic [MW-1:0] m_o,
  output logic [SW-1:0] s_o
);
  localparam int WW = FW + MW + S_LAST + 1;
  localparam logic [SW-1:0] S_END = SW'(S_LAST);
  localparam logic [PW-1:0] P_BEG = PW'(P_FIRST);
  localparam logic [PW-1:0] P_END = PW'(P_LAST);
  localparam logic [MW-1:0] M_BEG = MW'(M_FIRST);
  localparam logic [MW-1:0] M_END = MW'(M_LAST);

  typedef enum logic [1:0] {IDLE, GATE, SCAN} state_t;
  state_t state;

  logic [FW-1:0] fin_q, fout_q;
  logic [SW-1:0] s_q;
  logic [PW-1:0] p_q;
  logic [MW-1:0] m_q;
  logic          busy;

  logic [WW-1:0] fvco, prod_lo, prod_hi, lo, hi;
  logic          in_win, hit, m_stop;

  assign busy    = (state != IDLE);
  assign fvco    = WW'(fout_q) << s_q;
  assign prod_lo = WW'(fin_q) * WW'(m_q);
  assign prod_hi = prod_lo + WW'(fin_q);
  assign lo      = prod_lo / WW'(p_q);
  assign hi      = prod_hi / WW'(p_q);
  assign in_win  = (fvco >= WW'(VCO_MIN)) && (fvco <= WW'(VCO_MAX));
  assign hit     = (fvco >= lo) && (fvco < hi);
  assign m_stop  = (lo > fvco) || (m_q == M_END);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= IDLE;
      fin_q  <= '0;
      fout_q <= '0;
      s_q    <= '0;
      p_q    <= P_BEG;
      m_q    <= M_BEG;
      done   <= 1'b0;
      found  <= 1'b0;
      p_o    <= '0;
      m_o    <= '0;
      s_o    <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        IDLE: if (start) begin
          fin_q  <= fin;
          fout_q <= fout;
          s_q    <= '0;
          state  <= GATE;
        end
        GATE: begin
          if (in_win) begin
            p_q   <= P_BEG;
            m_q   <= M_BEG;
            state <= SCAN;
          end else if (s_q == S_END) begin
            done  <= 1'b1;
            found <= 1'b0;
            p_o   <= '0;
            m_o   <= '0;
            s_o   <= '0;
            state <= IDLE;
          end else begin
            s_q <= s_q + 1'b1;
          end
        end
        SCAN: begin
          if (hit) begin
            done  <= 1'b1;
            found <= 1'b1;
            p_o   <= p_q;
            m_o   <= m_q;
            s_o   <= s_q;
            state <= IDLE;
          end else if (m_stop) begin
            if (p_q != P_END) begin
              p_q <= p_q + 1'b1;
              m_q <= M_BEG;
            end else if (s_q == S_END) begin
              done  <= 1'b1;
              found <= 1'b0;
              p_o   <= '0;
              m_o   <= '0;
              s_o   <= '0;
              state <= IDLE;
            end else begin
              s_q   <= s_q + 1'b1;
              state <= GATE;
            end
          end else begin
            m_q <= m_q + 1'b1;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_param_search_chk.sv
module pll_param_search_chk #(
  parameter int FW = 64,
  parameter logic [63:0] VCO_MIN = 64'd2250000000,
  parameter logic [63:0] VCO_MAX = 64'd4500000000,
  parameter int SW = 3,
  parameter int PW = 3,
  parameter int MW = 10,
  parameter int S_LAST = 6,
  parameter int P_FIRST = 1,
  parameter int P_LAST = 4,
  parameter int M_FIRST = 64,
  parameter int M_LAST = 1023
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic [FW-1:0] fout_q,
  input logic          done,
  input logic          found,
  input logic [PW-1:0] p_o,
  input logic [MW-1:0] m_o,
  input logic [SW-1:0] s_o
);
  logic [FW+S_LAST:0] vco_out;
  assign vco_out = (FW+S_LAST+1)'(fout_q) << s_o;

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({found, p_o, m_o, s_o}));

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));

  assert_field_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && found) |-> (32'(p_o) >= P_FIRST && 32'(p_o) <= P_LAST &&
                         32'(m_o) >= M_FIRST && 32'(m_o) <= M_LAST &&
                         32'(s_o) <= S_LAST));

  assert_vco_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && found) |-> (vco_out >= (FW+S_LAST+1)'(VCO_MIN) &&
                         vco_out <= (FW+S_LAST+1)'(VCO_MAX)));

  assert_miss_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !found) |-> (p_o == '0 && m_o == '0 && s_o == '0));
endmodule

bind pll_param_search pll_param_search_chk #(
  .FW(FW), .VCO_MIN(VCO_MIN), .VCO_MAX(VCO_MAX),
  .SW(SW), .PW(PW), .MW(MW),
  .S_LAST(S_LAST), .P_FIRST(P_FIRST), .P_LAST(P_LAST),
  .M_FIRST(M_FIRST), .M_LAST(M_LAST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .fout_q(fout_q),
  .done(done), .found(found), .p_o(p_o), .m_o(m_o), .s_o(s_o)
);

// File: tb/pll_param_search_tb.sv
`timescale 1ns/1ps
module pll_param_search_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] fin = '0;
  logic [63:0] fout = '0;
  logic        done, found;
  logic [2:0]  p_o;
  logic [9:0]  m_o;
  logic [2:0]  s_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pll_param_search u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .fin(fin), .fout(fout),
    .done(done), .found(found), .p_o(p_o), .m_o(m_o), .s_o(s_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  typedef struct { bit f; int p; int m; int s; } res_t;

  function automatic res_t model(input longint unsigned fi, input longint unsigned fo);
    res_t r;
    r = '{0, 0, 0, 0};
    for (int s = 0; s <= 6; s++) begin
      logic [127:0] v;
      v = 128'(fo) << s;
      if (v < 128'd2250000000 || v > 128'd4500000000) continue;
      for (int p = 1; p <= 4; p++)
        for (int m = 64; m <= 1023; m++) begin
          logic [127:0] a, b;
          a = (128'(fi) * 128'(m)) / 128'(p);
          b = (128'(fi) * 128'(m + 1)) / 128'(p);
          if (v >= a && v < b) begin
            r = '{1, p, m, s};
            return r;
          end
        end
    end
    return r;
  endfunction

  task automatic kick(input longint unsigned fi, input longint unsigned fo);
    @(negedge clk);
    fin = fi; fout = fo; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 1;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic check_result(input string tag, input longint unsigned fi, input longint unsigned fo);
    res_t e;
    int c;
    e = model(fi, fo);
    wait_done(c);
    chk(done, {tag, " done"}, done, 1);
    chk(found == e.f, {tag, " found"}, found, e.f);
    chk(p_o == 3'(e.p), {tag, " p"}, p_o, e.p);
    chk(m_o == 10'(e.m), {tag, " m"}, m_o, e.m);
    chk(s_o == 3'(e.s), {tag, " s"}, s_o, e.s);
    @(negedge clk);
    chk(!done, "R6 done pulse width", done, 0);
    repeat (5) @(negedge clk);
    chk(found == e.f && p_o == 3'(e.p) && m_o == 10'(e.m) && s_o == 3'(e.s),
        "R6 outputs hold", {found, p_o, m_o, s_o}, {e.f, 3'(e.p), 10'(e.m), 3'(e.s)});
  endtask

  task automatic t_reset;
    chk(!done && !found && p_o == 0 && m_o == 0 && s_o == 0, "R8 reset state",
        {done, found, p_o, m_o, s_o}, 0);
  endtask

  task automatic t_known;
    res_t e;
    e = model(64'd24000000, 64'd1500000000);
    chk(e.f && e.s == 1 && e.p == 1 && e.m == 125, "R4 model anchor", e.m, 125);
    kick(64'd24000000, 64'd1500000000);
    check_result("R4 R1 24M->1.5G", 64'd24000000, 64'd1500000000);
  endtask

  task automatic t_higher_s;
    kick(64'd24000000, 64'd1100000000);
    check_result("R1 R3 24M->1.1G", 64'd24000000, 64'd1100000000);
    kick(64'd24000000, 64'd100000000);
    check_result("R1 24M->100M", 64'd24000000, 64'd100000000);
  endtask

  task automatic t_early_stop;
    kick(64'd100000000, 64'd1130000000);
    check_result("R9 R3 100M->1.13G", 64'd100000000, 64'd1130000000);
    kick(64'd50000000, 64'd786000000);
    check_result("R9 50M->786M", 64'd50000000, 64'd786000000);
  endtask

  task automatic t_window_latency;
    int n;
    @(negedge clk);
    fin = 64'd24000000; fout = 64'd5000000000; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 50) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    chk(n == 7, "R2 all-rejected latency", n, 7);
    chk(!found && p_o == 0 && m_o == 0 && s_o == 0, "R5 miss fields", {found, p_o, m_o, s_o}, 0);
    @(negedge clk);
    chk(!done, "R6 done pulse width", done, 0);
  endtask

  task automatic t_not_found;
    kick(64'd1000000, 64'd1500000000);
    check_result("R5 1M->1.5G", 64'd1000000, 64'd1500000000);
    kick(64'd24000000, 64'd0);
    check_result("R5 R2 zero target", 64'd24000000, 64'd0);
  endtask

  task automatic t_busy_start;
    kick(64'd24000000, 64'd1100000000);
    repeat (3) @(negedge clk);
    fin = 64'd24000000; fout = 64'd1500000000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check_result("R7 start during scan", 64'd24000000, 64'd1100000000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_known();
    t_higher_s();
    t_early_stop();
    t_window_latency();
    t_not_found();
    t_busy_start();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule